// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port

This block controls eight general-purpose pads from a small register bus. Software sets a per-pin direction bit and an output data latch. It can read back either the latch or the live levels on the pads. Each pin's behaviour is set by its two bits:

| Direction bit | Latch bit | Pin behaviour |
|---|---|---|
| 0 | 0 | Floating input |
| 0 | 1 | Input with its pull-up switched on |
| 1 | 0 | Driven low |
| 1 | 1 | Driven high |

So the latch bit has two uses: it is the drive level on an output and the pull-up switch on an input.

Three pins can be handed to timers. Two timer compare outputs can take over the drive value of their pins. One pin's level is passed on, after synchronization, as a capture input. Incoming pad levels go through a two-flop synchronizer before they reach either the read path or the capture output.

Top module: `gpio_port`

## Requirements
- R1: Offset 0x12 holds the output data latch. A bus write to it updates the latch on that clock edge, and reading it returns the latch contents.
- R2: Offset 0x11 holds the direction register (1 = output). A write to it takes effect on that clock edge, and reading it returns the stored value.
- R3: Reading offset 0x10 returns the pad input levels as they were two clock edges earlier. Writing to 0x10 changes neither register, nor any pad control output.
- R4: Reading any offset other than 0x10, 0x11 or 0x12 returns 0x00, and writing to one changes no state.
- R5: After a clocked reset, both the latch and the direction register read 0x00, and every pad is undriven with its pull-up off.
- R6: While reset is high, pad_oe and pad_pu are all zero at once, before any clock edge.
- R7: Outside reset, pad_oe[n] equals direction bit n. pad_out[n] equals latch bit n unless R9 or R10 overrides it.
- R8: pad_pu[n] is 1 exactly when direction bit n is 0 and latch bit n is 1. pad_pu and pad_oe are never both 1 on the same pin.
- R9: When t2_cmp_en is 1 and direction bit 7 is 1, pad_out[7] follows t2_cmp_val. When direction bit 7 is 0, pin 7 stays undriven whatever the timer does.
- R10: When t1a_cmp_en is 1 and direction bit 5 is 1, pad_out[5] follows t1a_cmp_val. When direction bit 5 is 0, pin 5 stays undriven.
- R11: t1_capture equals pad_in[6] delayed by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset. It is clocked for the registers and immediate for the pad tri-state |
| bus_addr | input | 6 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pad_in | input | 8 | Levels seen on the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin drive value |
| pad_pu | output | 8 | Per-pin pull-up enable |
| t2_cmp_en | input | 1 | Timer 2 compare output enable for pin 7 |
| t2_cmp_val | input | 1 | Timer 2 compare/PWM level |
| t1a_cmp_en | input | 1 | Timer 1 compare A output enable for pin 5 |
| t1a_cmp_val | input | 1 | Timer 1 compare A/PWM level |
| t1_capture | output | 1 | Synchronized pin 6 level for the timer 1 capture input |

## Verification
The following are checked on every clock:
- the tri-state during reset;
- that pull-up and drive are never on together on one pin;
- the two-clock lag on pin reads and on the capture output;
- that a read of an unmapped offset returns zero;
- that the timer compare overrides take effect;
- that writes to the latch and direction offsets land, and that writes to the pin-read or unmapped offsets leave the pad controls unchanged.

Some properties can only be shown by the bench's scenarios:
- the full four-way pin table under mixed random register contents;
- that the reset tri-state appears before any clock edge;
- that the synchronizer does not yet show a new pad level after only one clock.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_PINS  = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 6'h11;
    localparam logic [ADDR_W-1:0] OFS_LATCH = 6'h12;

    localparam int PIN_T2_CMP  = 7;
    localparam int PIN_T1_CAP  = 6;
    localparam int PIN_T1A_CMP = 5;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_PINS,
        SEL_DIR,
        SEL_LATCH
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pad_ctl_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
        reg_sel_e sel;
        unique case (ofs)
            OFS_PINS:  sel = SEL_PINS;
            OFS_DIR:   sel = SEL_DIR;
            OFS_LATCH: sel = SEL_LATCH;
            default:   sel = SEL_NONE;
        endcase
        return sel;
    endfunction

    // Resolve one pin from its direction bit, latch bit and optional alternate driver.
    function automatic pad_ctl_t resolve_pin(input logic dir, input logic lat,
                                             input logic alt_en, input logic alt_val,
                                             input logic force_off);
        pad_ctl_t c;
        c.oe  = dir & ~force_off;
        c.out = (dir & alt_en) ? alt_val : lat;
        c.pu  = ~dir & lat & ~force_off;
        return c;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= '0;
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = PORT_W,
    parameter int AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);
    reg_sel_e sel;

    assign sel = decode_ofs(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else if (wr) begin
            if (sel == SEL_LATCH) latch_q <= wdata;
            if (sel == SEL_DIR)   dir_q   <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_PINS:  rdata = pins_sync;
            SEL_DIR:   rdata = dir_q;
            SEL_LATCH: rdata = latch_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
    import gpio_pkg::*;
#(
    parameter int WIDTH   = PORT_W,
    parameter int ALT_A   = PIN_T2_CMP,
    parameter int ALT_B   = PIN_T1A_CMP
) (
    input  logic             rst,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] latch,
    input  logic             alt_a_en,
    input  logic             alt_a_val,
    input  logic             alt_b_en,
    input  logic             alt_b_val,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] out,
    output logic [WIDTH-1:0] pu
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pad_ctl_t ctl;
        if (i == ALT_A) begin : g_alt_a
            assign ctl = resolve_pin(dir[i], latch[i], alt_a_en, alt_a_val, rst);
        end else if (i == ALT_B) begin : g_alt_b
            assign ctl = resolve_pin(dir[i], latch[i], alt_b_en, alt_b_val, rst);
        end else begin : g_plain
            assign ctl = resolve_pin(dir[i], latch[i], 1'b0, 1'b0, rst);
        end
        assign oe[i]  = ctl.oe;
        assign out[i] = ctl.out;
        assign pu[i]  = ctl.pu;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH   = PORT_W,
    parameter int AW      = ADDR_W,
    parameter int T2_PIN  = PIN_T2_CMP,
    parameter int CAP_PIN = PIN_T1_CAP,
    parameter int T1A_PIN = PIN_T1A_CMP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_pu,
    input  logic             t2_cmp_en,
    input  logic             t2_cmp_val,
    input  logic             t1a_cmp_en,
    input  logic             t1a_cmp_val,
    output logic             t1_capture
);
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pins_sync)
    );

    gpio_regs #(.WIDTH(WIDTH), .AW(AW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .pins_sync (pins_sync),
        .rdata     (bus_rdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q)
    );

    gpio_pin_ctl #(.WIDTH(WIDTH), .ALT_A(T2_PIN), .ALT_B(T1A_PIN)) u_pins (
        .rst       (rst),
        .dir       (dir_q),
        .latch     (latch_q),
        .alt_a_en  (t2_cmp_en),
        .alt_a_val (t2_cmp_val),
        .alt_b_en  (t1a_cmp_en),
        .alt_b_val (t1a_cmp_val),
        .oe        (pad_oe),
        .out       (pad_out),
        .pu        (pad_pu)
    );

    assign t1_capture = pins_sync[CAP_PIN];
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int WIDTH   = PORT_W,
    parameter int AW      = ADDR_W,
    parameter int T2_PIN  = PIN_T2_CMP,
    parameter int CAP_PIN = PIN_T1_CAP,
    parameter int T1A_PIN = PIN_T1A_CMP
) (
    input logic             clk,
    input logic             rst,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_wr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] bus_rdata,
    input logic [WIDTH-1:0] pad_in,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_pu,
    input logic             t2_cmp_en,
    input logic             t2_cmp_val,
    input logic             t1a_cmp_en,
    input logic             t1a_cmp_val,
    input logic             t1_capture
);
    logic [1:0] cyc;
    logic       wr_pins_or_none;

    always_ff @(posedge clk) begin
        if (rst)            cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    assign wr_pins_or_none = bus_wr && (bus_addr != OFS_LATCH) && (bus_addr != OFS_DIR);

    always_comb begin
        if (rst === 1'b1) begin
            AST_RST_TRISTATE: assert (pad_oe == '0 && pad_pu == '0); // R6
        end
    end

    AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && bus_addr == OFS_LATCH && $past(bus_wr && bus_addr == OFS_LATCH))
        |-> bus_rdata == $past(bus_wdata)); // R1

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && $past(bus_wr && bus_addr == OFS_DIR)) |-> pad_oe == $past(bus_wdata)); // R2

    AST_PIN_READ_LAG: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && bus_addr == OFS_PINS) |-> bus_rdata == $past(pad_in, 2)); // R3

    AST_NOWRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd1 && $past(wr_pins_or_none)) |-> ($stable(pad_oe) && $stable(pad_pu))); // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != OFS_PINS && bus_addr != OFS_DIR && bus_addr != OFS_LATCH) |-> bus_rdata == '0); // R4

    AST_PU_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & pad_pu) == '0); // R8

    AST_T2_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        (pad_oe[T2_PIN] && t2_cmp_en) |-> pad_out[T2_PIN] == t2_cmp_val); // R9

    AST_T1A_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        (pad_oe[T1A_PIN] && t1a_cmp_en) |-> pad_out[T1A_PIN] == t1a_cmp_val); // R10

    AST_CAPTURE_LAG: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> t1_capture == $past(pad_in[CAP_PIN], 2)); // R11
endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH(WIDTH), .AW(AW), .T2_PIN(T2_PIN), .CAP_PIN(CAP_PIN), .T1A_PIN(T1A_PIN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pu      (pad_pu),
    .t2_cmp_en   (t2_cmp_en),
    .t2_cmp_val  (t2_cmp_val),
    .t1a_cmp_en  (t1a_cmp_en),
    .t1a_cmp_val (t1a_cmp_val),
    .t1_capture  (t1_capture)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] bus_addr = 6'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out, pad_pu;
    logic       t2_cmp_en = 1'b0, t2_cmp_val = 1'b0;
    logic       t1a_cmp_en = 1'b0, t1a_cmp_val = 1'b0;
    logic       t1_capture;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    logic [7:0] m_lat = 8'h00;
    logic [7:0] m_dir = 8'h00;

    always #2.5 clk = ~clk;

    gpio_port dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
        .t2_cmp_en(t2_cmp_en), .t2_cmp_val(t2_cmp_val),
        .t1a_cmp_en(t1a_cmp_en), .t1a_cmp_val(t1a_cmp_val),
        .t1_capture(t1_capture)
    );

    function automatic logic [7:0] exp_out(input logic [7:0] d, input logic [7:0] l,
                                           input logic e2, input logic v2,
                                           input logic e1, input logic v1);
        logic [7:0] r = l;
        if (d[7] && e2) r[7] = v2;
        if (d[5] && e1) r[5] = v1;
        return r;
    endfunction

    function automatic logic [7:0] exp_pu(input logic [7:0] d, input logic [7:0] l);
        return ~d & l;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 6'h12) m_lat = d;
        if (a == 6'h11) m_dir = d;
    endtask

    task automatic read_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic pads_chk;
        #0.5;
        check("R7 oe", pad_oe, m_dir);
        check("R7/R9/R10 out", pad_out,
              exp_out(m_dir, m_lat, t2_cmp_en, t2_cmp_val, t1a_cmp_en, t1a_cmp_val));
        check("R8 pu", pad_pu, exp_pu(m_dir, m_lat));
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5 state during and after clocked reset
        check("R6 oe in reset", pad_oe, 8'h00);
        check("R6 pu in reset", pad_pu, 8'h00);
        rst = 1'b0;
        read_chk("R5 latch reset", 6'h12, 8'h00);
        read_chk("R5 dir reset", 6'h11, 8'h00);
        check("R5 oe", pad_oe, 8'h00);
        check("R5 pu", pad_pu, 8'h00);

        // R1/R2 directed, four-way table on pins
        bus_write(6'h11, 8'hCC);
        bus_write(6'h12, 8'hAA);
        read_chk("R1 latch readback", 6'h12, 8'hAA);
        read_chk("R2 dir readback", 6'h11, 8'hCC);
        pads_chk();

        // R3 write to pin offset ignored
        bus_write(6'h10, 8'h55);
        m_lat = 8'hAA; m_dir = 8'hCC;
        read_chk("R3 latch untouched", 6'h12, 8'hAA);
        read_chk("R3 dir untouched", 6'h11, 8'hCC);
        pads_chk();

        // R4 unmapped offsets
        bus_write(6'h13, 8'hFF);
        bus_write(6'h00, 8'h0F);
        read_chk("R4 unmapped read", 6'h13, 8'h00);
        read_chk("R4 unmapped read", 6'h3F, 8'h00);
        read_chk("R4 latch untouched", 6'h12, 8'hAA);
        read_chk("R4 dir untouched", 6'h11, 8'hCC);
        pads_chk();

        // R3 / R11 synchronizer lag
        @(negedge clk);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hC3;
        @(negedge clk);
        read_chk("R3 one edge: old level", 6'h10, 8'h00);
        check("R11 one edge: old level", {7'd0, t1_capture}, 8'h00);
        @(negedge clk);
        read_chk("R3 two edges: new level", 6'h10, 8'hC3);
        check("R11 two edges", {7'd0, t1_capture}, 8'h01);

        // R9/R10 overrides, with direction set and clear
        bus_write(6'h11, 8'hA0);
        bus_write(6'h12, 8'h00);
        t2_cmp_en = 1'b1; t2_cmp_val = 1'b1; t1a_cmp_en = 1'b1; t1a_cmp_val = 1'b1;
        pads_chk();
        check("R9 pin7 override", {7'd0, pad_out[7]}, 8'h01);
        check("R10 pin5 override", {7'd0, pad_out[5]}, 8'h01);
        bus_write(6'h11, 8'h00);
        pads_chk();
        check("R9/R10 undriven when input", pad_oe & 8'hA0, 8'h00);

        // Random mix
        for (int it = 0; it < 300; it++) begin
            int unsigned pick = $urandom_range(0, 4);
            logic [5:0] a;
            case (pick)
                0: a = 6'h10;
                1: a = 6'h11;
                2, 3: a = 6'h12;
                default: a = 6'($urandom);
            endcase
            t2_cmp_en   = 1'($urandom); t2_cmp_val  = 1'($urandom);
            t1a_cmp_en  = 1'($urandom); t1a_cmp_val = 1'($urandom);
            pad_in = 8'($urandom);
            bus_write(a, 8'($urandom));
            pads_chk();
            if (it % 8 == 0) begin
                read_chk("R1 random latch", 6'h12, m_lat);
                read_chk("R2 random dir", 6'h11, m_dir);
            end
            if (a != 6'h10 && a != 6'h11 && a != 6'h12)
                read_chk("R4 random unmapped", a, 8'h00);
        end

        // R6 immediate tri-state on reset, then R5 clocked clear
        bus_write(6'h11, 8'h0F);
        bus_write(6'h12, 8'hFF);
        #1;
        rst = 1'b1;
        #0.5;
        check("R6 oe immediate", pad_oe, 8'h00);
        check("R6 pu immediate", pad_pu, 8'h00);
        @(negedge clk);
        m_lat = 8'h00; m_dir = 8'h00;
        read_chk("R5 latch cleared", 6'h12, 8'h00);
        read_chk("R5 dir cleared", 6'h11, 8'h00);
        rst = 1'b0;
        pads_chk();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule